// File: doc/BRIEF.md
# Sub-word insert and extract unit

This unit is a datapath slice for a 16-bit or 32-bit core that works on bytes and halfwords inside a register-wide word. It has two directions. An insert writes the low byte or low halfword of a data operand into a chosen byte lane of a receiving word. An extract reads a byte or halfword out of a word and widens it with sign or zero extension. A third read operand gives the byte offset. That offset comes either from the low address bits of a register or from a short immediate.

If a halfword is placed at the last byte lane, it would cross the word boundary. In that case the unit handles only the one byte that fits and raises a carry indication instead of trapping. Following conditional code can then finish the access in the next word. The unit also has a move-high operation: it places an immediate in the upper half of the destination, so that a later OR can fill the lower half.

The result and the carry are registered. Operands presented at a clock edge show up at the outputs right after that edge. Register reads, decode and memory are handled elsewhere.

Top module: `iex_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first operation is registered, `result_o` and `carry_o` are 0.
- R2: Operands sampled at a rising clock edge set `result_o` and `carry_o` right after that same edge, with one register stage in total.
- R3: The byte lane is the low log2(XLEN/8) bits of `off_reg_i`, or of `off_imm_i` when `off_use_imm_i` is 1. All higher bits of both offset sources have no effect.
- R4: Byte insert (op 0) writes `ins_data_i[7:0]` into the selected lane of `word_i`. Every other lane keeps the value it has in `word_i`.
- R5: Halfword insert (op 1) at a lane below the top lane writes `ins_data_i[7:0]` into the selected lane and `ins_data_i[15:8]` into the next higher lane. Every other lane keeps the value it has in `word_i`.
- R6: Byte extract reads the selected lane of `word_i`. Op 2 sign-extends it from its bit 7. Op 3 zero-extends it.
- R7: Halfword extract at a lane below the top lane reads that lane (low byte) and the next lane (high byte). Op 4 sign-extends the halfword from its bit 15. Op 5 zero-extends it.
- R8: A halfword operation (op 1, 4 or 5) at the top lane (lane 3 when XLEN=32, lane 1 when XLEN=16) sets `carry_o`. In that case op 1 writes only `ins_data_i[7:0]` into the top lane. Ops 4 and 5 return only the top byte, sign-extended from its bit 7 (op 4) or zero-extended (op 5).
- R9: `carry_o` is 0 after every operation other than the top-lane halfword case of R8.
- R10: Move-high (op 6) returns the low XLEN/2 bits of `imm16_i` in the upper half of `result_o`, with the lower half 0.
- R11: Op 7 returns a zero result with carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code (0 to 7, see R4 to R11) |
| ins_data_i | input | XLEN | Data operand; its low byte or low halfword is inserted |
| word_i | input | XLEN | Receiving word for insert, source word for extract |
| off_reg_i | input | XLEN | Register operand that supplies the byte offset |
| off_imm_i | input | 4 | Immediate byte offset |
| off_use_imm_i | input | 1 | 1 selects `off_imm_i` as the offset source |
| imm16_i | input | 16 | Immediate for move-high |
| result_o | output | XLEN | Registered result |
| carry_o | output | 1 | Registered boundary-straddle indication |

## Verification
The bench targets the lane arithmetic at both ends of the word. A halfword at the top lane is the main case. A design that wrapped the high byte into lane 0 would corrupt the low byte of the receiving word. A design that forgot the straddle would leave carry low, so the software fix-up would never run.

Sign extension is checked with lane contents that have bit 7 or bit 15 set. Extending from the wrong bit, or extending when the operation asks for zero fill, changes the upper bits of the result.

Offset operands carry set bits above the lane field. A unit that decoded too many bits would pick the wrong lane or miss the wrap. The immediate path is checked the same way as the register path.

// File: rtl/iex_pkg.sv
package iex_pkg;

    typedef enum logic [2:0] {
        IEX_INS_B  = 3'd0,
        IEX_INS_H  = 3'd1,
        IEX_EXT_SB = 3'd2,
        IEX_EXT_ZB = 3'd3,
        IEX_EXT_SH = 3'd4,
        IEX_EXT_ZH = 3'd5,
        IEX_MOV_HI = 3'd6,
        IEX_NONE   = 3'd7
    } iex_op_e;

endpackage

// File: rtl/iex_lane_sel.sv
module iex_lane_sel #(
    parameter int XLEN = 32,
    parameter int LANE_W = $clog2(XLEN / 8)
) (
    input  logic [XLEN-1:0]   off_reg_i,
    input  logic [3:0]        off_imm_i,
    input  logic              off_use_imm_i,
    output logic [LANE_W-1:0] lane_o,
    output logic              top_lane_o
);
    localparam int NB = XLEN / 8;

    logic unused_off_hi;
    assign unused_off_hi = ^{off_reg_i[XLEN-1:LANE_W], off_imm_i[3:LANE_W]};

    always_comb begin
        lane_o     = off_use_imm_i ? off_imm_i[LANE_W-1:0] : off_reg_i[LANE_W-1:0];
        top_lane_o = (lane_o == LANE_W'(NB - 1));
    end
endmodule

// File: rtl/iex_insert.sv
module iex_insert #(
    parameter int XLEN = 32,
    parameter int LANE_W = $clog2(XLEN / 8)
) (
    input  logic [XLEN-1:0]   data_i,
    input  logic [XLEN-1:0]   word_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic              half_i,
    output logic [XLEN-1:0]   result_o
);
    localparam int NB = XLEN / 8;

    logic unused_data_hi;
    assign unused_data_hi = ^data_i[XLEN-1:16];

    for (genvar k = 0; k < NB; k++) begin : g_lane
        logic [7:0] byte_d;
        if (k == 0) begin : g_first
            always_comb begin
                byte_d = word_i[7:0];
                if (lane_i == LANE_W'(0)) byte_d = data_i[7:0];
            end
        end else begin : g_rest
            always_comb begin
                byte_d = word_i[8*k +: 8];
                if (lane_i == LANE_W'(k))
                    byte_d = data_i[7:0];
                else if (half_i && lane_i == LANE_W'(k - 1))
                    byte_d = data_i[15:8];
            end
        end
        assign result_o[8*k +: 8] = byte_d;
    end
endmodule

// File: rtl/iex_extract.sv
module iex_extract #(
    parameter int XLEN = 32,
    parameter int LANE_W = $clog2(XLEN / 8)
) (
    input  logic [XLEN-1:0]   word_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic              half_i,
    input  logic              sext_i,
    input  logic              top_lane_i,
    output logic [XLEN-1:0]   result_o
);
    logic [XLEN-1:0] shifted;
    logic [7:0]      b;
    logic [15:0]     h;

    always_comb begin
        shifted = word_i >> {lane_i, 3'b000};
        b       = shifted[7:0];
        h       = shifted[15:0];
        if (half_i && !top_lane_i)
            result_o = sext_i ? XLEN'($signed(h)) : XLEN'(h);
        else
            result_o = sext_i ? XLEN'($signed(b)) : XLEN'(b);
    end
endmodule

// File: rtl/iex_unit.sv
module iex_unit
    import iex_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_i,
    input  logic [XLEN-1:0] ins_data_i,
    input  logic [XLEN-1:0] word_i,
    input  logic [XLEN-1:0] off_reg_i,
    input  logic [3:0]      off_imm_i,
    input  logic            off_use_imm_i,
    input  logic [15:0]     imm16_i,
    output logic [XLEN-1:0] result_o,
    output logic            carry_o
);
    localparam int LANE_W = $clog2(XLEN / 8);
    localparam int HALF   = XLEN / 2;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            carry;
        logic            primed;
    } state_t;

    state_t state_d, state_q;
    iex_op_e op;
    logic [LANE_W-1:0] lane;
    logic top_lane, is_half, sext;
    logic [XLEN-1:0] ins_res, ext_res;

    assign op = iex_op_e'(op_i);
    assign is_half = (op == IEX_INS_H) || (op == IEX_EXT_SH) || (op == IEX_EXT_ZH);
    assign sext = (op == IEX_EXT_SB) || (op == IEX_EXT_SH);

    logic unused_imm_hi;
    assign unused_imm_hi = ^imm16_i;

    iex_lane_sel #(.XLEN(XLEN), .LANE_W(LANE_W)) u_lane (
        .off_reg_i(off_reg_i), .off_imm_i(off_imm_i), .off_use_imm_i(off_use_imm_i),
        .lane_o(lane), .top_lane_o(top_lane)
    );

    iex_insert #(.XLEN(XLEN), .LANE_W(LANE_W)) u_ins (
        .data_i(ins_data_i), .word_i(word_i), .lane_i(lane),
        .half_i(op == IEX_INS_H), .result_o(ins_res)
    );

    iex_extract #(.XLEN(XLEN), .LANE_W(LANE_W)) u_ext (
        .word_i(word_i), .lane_i(lane), .half_i(is_half), .sext_i(sext),
        .top_lane_i(top_lane), .result_o(ext_res)
    );

    always_comb begin
        state_d        = state_q;
        state_d.primed = 1'b1;
        state_d.carry  = is_half && top_lane;
        unique case (op)
            IEX_INS_B, IEX_INS_H: state_d.result = ins_res;
            IEX_EXT_SB, IEX_EXT_ZB, IEX_EXT_SH, IEX_EXT_ZH: state_d.result = ext_res;
            IEX_MOV_HI: state_d.result = {imm16_i[HALF-1:0], {HALF{1'b0}}};
            default: state_d.result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result_o = state_q.result;
    assign carry_o  = state_q.carry;

    // R8
    carry_only_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.primed && carry_o) |-> $past(is_half));

    // R9
    no_carry_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.primed && $past(op_i) inside {3'd0, 3'd2, 3'd3, 3'd6, 3'd7}) |-> !carry_o);

    // R10
    movhi_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.primed && $past(op_i) == 3'd6) |-> result_o[HALF-1:0] == '0);

    // R6
    zext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.primed && $past(op_i) == 3'd3) |-> result_o[XLEN-1:8] == '0);

    // R6
    sext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.primed && $past(op_i) == 3'd2) |-> result_o[XLEN-1:8] == {(XLEN-8){result_o[7]}});

    // R4
    ins_keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.primed && $past(op_i) == 3'd0 && $past(lane) == '0)
        |-> result_o[XLEN-1:8] == $past(word_i[XLEN-1:8]));

    // R11
    none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.primed && $past(op_i) == 3'd7) |-> (result_o == '0 && !carry_o));
endmodule

// File: tb/iex_unit_test.sv
module iex_unit_test;
    localparam int W  = 32;
    localparam int NB = W / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] op = '0;
    logic [W-1:0] data = '0, word = '0, offr = '0;
    logic [3:0] offi = '0;
    logic use_imm = 1'b0;
    logic [15:0] imm16 = '0;
    logic [W-1:0] result;
    logic carry;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    iex_unit #(.XLEN(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .ins_data_i(data), .word_i(word),
        .off_reg_i(offr), .off_imm_i(offi), .off_use_imm_i(use_imm),
        .imm16_i(imm16), .result_o(result), .carry_o(carry)
    );

    function automatic string req_of(input int o);
        case (o)
            0: return "R4";
            1: return "R5/R8";
            2, 3: return "R6";
            4, 5: return "R7/R8";
            6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] er, input logic ec);
        vectors++;
        if (result !== er || carry !== ec) begin
            errors++;
            $display("FAIL %s op=%0d: got result=%h carry=%b, expected result=%h carry=%b",
                     req, op, result, carry, er, ec);
        end
    endtask

    task automatic apply(input int o, input logic [W-1:0] d, input logic [W-1:0] w,
                         input logic [W-1:0] r, input logic [3:0] im, input logic ui,
                         input logic [15:0] i16);
        logic [W-1:0] er;
        logic ec;
        int lane;
        logic [7:0] b;
        logic [15:0] h;
        op = 3'(o); data = d; word = w; offr = r; offi = im; use_imm = ui; imm16 = i16;
        lane = ui ? int'(im) % NB : int'(r % W'(NB));
        er = '0; ec = 1'b0;
        b = 8'((w >> (8 * lane)) & 'hFF);
        h = 16'((w >> (8 * lane)) & 'hFFFF);
        case (o)
            0: begin er = w; er[8*lane +: 8] = d[7:0]; end
            1: begin
                er = w; er[8*lane +: 8] = d[7:0];
                if (lane < NB - 1) er[8*lane+8 +: 8] = d[15:8]; else ec = 1'b1;
            end
            2: er = W'($signed(b));
            3: er = W'(b);
            4, 5: begin
                if (lane < NB - 1) er = (o == 4) ? W'($signed(h)) : W'(h);
                else begin
                    ec = 1'b1;
                    er = (o == 4) ? W'($signed(b)) : W'(b);
                end
            end
            6: er = W'(i16) << (W / 2);
            default: er = '0;
        endcase
        @(negedge clk);
        // R2: result visible one edge after operands; R3: lane from low offset bits only
        check(req_of(o), er, ec);
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] dpat [4];
        logic [W-1:0] wpat [4];
        dpat[0] = 32'h0000_A55A; wpat[0] = 32'h1122_3344;
        dpat[1] = 32'hDEAD_80FF; wpat[1] = 32'h80FF_7F01;
        dpat[2] = 32'h1234_7F80; wpat[2] = 32'hFFFF_FFFF;
        dpat[3] = 32'hFFFF_0000; wpat[3] = 32'h0000_0000;

        op = 3'd6; imm16 = 16'hBEEF; word = '1; data = '1;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs at zero despite live operands
        check("R1", '0, 1'b0);
        rst_n = 1'b1;
        check("R1", '0, 1'b0);

        for (int p = 0; p < 4; p++)
            for (int o = 0; o < 8; o++)
                for (int off = 0; off < 8; off++)
                    for (int ui = 0; ui < 2; ui++)
                        // R3: offsets 4..7 and high register bits must alias lanes 0..3
                        apply(o, dpat[p], wpat[p],
                              {W'(p) << 8, 5'b0, 3'(off)} | (W'(off) << 2),
                              4'(off + 8 * p), 1'(ui), 16'h8001 ^ 16'(p * 16'h1111));

        // R8: straddle through the immediate path with a sign-carrying top byte
        apply(4, '0, 32'h8000_0000, '0, 4'd3, 1'b1, '0);
        apply(1, 32'h0000_CDAB, 32'h0102_0304, 32'hFFFF_FFF3, '0, 1'b0, '0);
        // R9: carry cleared by a following aligned halfword
        apply(5, '0, 32'h0000_8001, '0, 4'd0, 1'b1, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule